// File: doc/BRIEF.md
# Keyed and Banked Configuration Register Port

This block is the configuration space of a multi-function I/O controller. The host reaches it through two byte ports: a pointer port and a value port. After reset the space is locked. Writing the unlock byte to the pointer port on two consecutive pointer writes opens it, and writing the lock byte closes it again. While the space is open, a pointer write selects a register and a value-port access then reads or writes that register.

Registers below pointer 0x30 are shared. They hold a device-select register, read-only identity bytes and a port-check byte. Registers at 0x30 and above are banked. The device-select register decides which function's bank they reach, so one pointer addresses a different register for each function. Each bank holds an enable, a 16-bit I/O base split into two bytes, and an interrupt-line select. These values drive the per-function outputs directly.

Top module: `sio_cfg_port`

## Requirements
- R1: The space opens only when the unlock byte (parameter, default 0x87) is written to the pointer port on two consecutive pointer writes. Any other pointer write between them restarts the sequence.
- R2: While open, writing the lock byte (parameter, default 0xAA) to the pointer port closes the space. Any other pointer write while open stores that byte as the current pointer.
- R3: A value-port read returns its result on `rd_data` in the cycle after the strobe. `rd_data` holds its value in every cycle without a read strobe.
- R4: Pointer 0x07 is the device-select register, readable and writable over all 8 bits. Pointers below 0x30 reach the same registers whatever device is selected.
- R5: For a selected device below NDEV, pointer 0x30 is its enable byte, with bit 0 driving `fn_enable[dev]`. Pointers 0x60 and 0x61 are its base high and low bytes, driving `fn_base[dev*16 +: 16]`. Pointer 0x70 is its interrupt select, driving `fn_irq[dev*8 +: 8]`. All four read back as written.
- R6: Pointers 0x20 and 0x21 return the chip ID high and low bytes. Pointers 0x23 and 0x24 return the vendor ID high and low bytes. Writes to these four pointers change nothing.
- R7: Pointer 0x26 is a read-only port-check byte that returns the PORT_CHECK parameter (default 0x4E), which never equals 0xFF. Writes to it change nothing.
- R8: While the space is not open, value-port reads return 0xFF and value-port writes change no register and no output.
- R9: Unmapped pointers read 0x00 and ignore writes. When the device-select value is NDEV or more, banked pointers read 0x00 and ignore writes.
- R10: A read-modify-write that changes one bit of a register leaves all its other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_wr | input | 1 | Pointer-port write strobe |
| val_wr | input | 1 | Value-port write strobe |
| val_rd | input | 1 | Value-port read strobe |
| wr_data | input | 8 | Byte written with either write strobe |
| rd_data | output | 8 | Registered read result |
| fn_enable | output | NDEV | Enable bit of each function |
| fn_base | output | 16*NDEV | I/O base of each function |
| fn_irq | output | 8*NDEV | Interrupt-line select of each function |

## Verification
The assertions assume at most one of the three strobes is active in any cycle, as on a byte bus that carries one transfer at a time. They also assume `wr_data` is meaningful only while a write strobe is high. The stimulus makes every transfer one strobe cycle followed by an idle cycle. Pointer bytes are drawn from a pool that mixes the two keys, every mapped pointer and unmapped ones. Device-select writes sometimes pick a number past the last bank.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_e;

  localparam logic [7:0] IX_DEVSEL  = 8'h07;
  localparam logic [7:0] IX_CHIP_H  = 8'h20;
  localparam logic [7:0] IX_CHIP_L  = 8'h21;
  localparam logic [7:0] IX_VEND_H  = 8'h23;
  localparam logic [7:0] IX_VEND_L  = 8'h24;
  localparam logic [7:0] IX_PCHK    = 8'h26;
  localparam logic [7:0] IX_BANKED  = 8'h30;
  localparam logic [7:0] IX_ENABLE  = 8'h30;
  localparam logic [7:0] IX_BASE_H  = 8'h60;
  localparam logic [7:0] IX_BASE_L  = 8'h61;
  localparam logic [7:0] IX_IRQSEL  = 8'h70;
endpackage

// File: rtl/sio_unlock_fsm.sv
module sio_unlock_fsm
  import sio_cfg_pkg::*;
#(
  parameter int          DW        = 8,
  parameter logic [7:0]  ENTRY_KEY = 8'h87,
  parameter logic [7:0]  EXIT_KEY  = 8'hAA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_wr,
  input  logic [DW-1:0] wr_data,
  output logic          is_open,
  output logic          is_half
);
  lock_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (ptr_wr) begin
      unique case (state_q)
        LK_SHUT: state_d = (wr_data == ENTRY_KEY) ? LK_HALF : LK_SHUT;
        LK_HALF: state_d = (wr_data == ENTRY_KEY) ? LK_OPEN : LK_SHUT;
        LK_OPEN: state_d = (wr_data == EXIT_KEY)  ? LK_SHUT : LK_OPEN;
        default: state_d = LK_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LK_SHUT;
    else     state_q <= state_d;
  end

  assign is_open = (state_q == LK_OPEN);
  assign is_half = (state_q == LK_HALF);
endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank
  import sio_cfg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [DW-1:0]   ptr,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   en_q,
  output logic [2*DW-1:0] base_q,
  output logic [DW-1:0]   irq_q,
  output logic [DW-1:0]   rd_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      base_q <= '0;
      irq_q  <= '0;
    end else if (wr_en) begin
      case (ptr)
        IX_ENABLE: en_q            <= wr_data;
        IX_BASE_H: base_q[2*DW-1:DW] <= wr_data;
        IX_BASE_L: base_q[DW-1:0]  <= wr_data;
        IX_IRQSEL: irq_q           <= wr_data;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (ptr)
      IX_ENABLE: rd_val = en_q;
      IX_BASE_H: rd_val = base_q[2*DW-1:DW];
      IX_BASE_L: rd_val = base_q[DW-1:0];
      IX_IRQSEL: rd_val = irq_q;
      default:   rd_val = '0;
    endcase
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          NDEV       = 2,
  parameter logic [7:0]  ENTRY_KEY  = 8'h87,
  parameter logic [7:0]  EXIT_KEY   = 8'hAA,
  parameter logic [15:0] CHIP_ID    = 16'h0C21,
  parameter logic [15:0] VENDOR_ID  = 16'h5A3C,
  parameter logic [7:0]  PORT_CHECK = 8'h4E
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ptr_wr,
  input  logic             val_wr,
  input  logic             val_rd,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic [NDEV-1:0]  fn_enable,
  output logic [16*NDEV-1:0] fn_base,
  output logic [8*NDEV-1:0]  fn_irq
);
  localparam int DW = 8;
  localparam int BW = 2 * DW;

  logic          cfg_open, key_half;
  logic [DW-1:0] ptr_q, devsel_q, glob_val, sel_val, rd_q;
  logic [DW-1:0] bank_rd [NDEV];
  logic          sel_ok;

  sio_unlock_fsm #(.DW(DW), .ENTRY_KEY(ENTRY_KEY), .EXIT_KEY(EXIT_KEY)) u_lock (
    .clk(clk), .rst(rst), .ptr_wr(ptr_wr), .wr_data(wr_data),
    .is_open(cfg_open), .is_half(key_half)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      devsel_q <= '0;
    end else begin
      if (cfg_open && ptr_wr && wr_data != EXIT_KEY) ptr_q <= wr_data;
      if (cfg_open && val_wr && ptr_q == IX_DEVSEL)  devsel_q <= wr_data;
    end
  end

  assign sel_ok = (devsel_q < DW'(NDEV));

  generate
    for (genvar g = 0; g < NDEV; g++) begin : g_bank
      logic [DW-1:0] en_w, irq_w;
      logic [BW-1:0] base_w;
      logic          wr_g;
      assign wr_g = cfg_open && val_wr && (ptr_q >= IX_BANKED) && (devsel_q == DW'(g));
      sio_ldev_bank #(.DW(DW)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_g), .ptr(ptr_q), .wr_data(wr_data),
        .en_q(en_w), .base_q(base_w), .irq_q(irq_w), .rd_val(bank_rd[g])
      );
      assign fn_enable[g]        = en_w[0];
      assign fn_base[g*BW +: BW] = base_w;
      assign fn_irq[g*DW +: DW]  = irq_w;
    end
  endgenerate

  always_comb begin
    case (ptr_q)
      IX_DEVSEL: glob_val = devsel_q;
      IX_CHIP_H: glob_val = CHIP_ID[15:8];
      IX_CHIP_L: glob_val = CHIP_ID[7:0];
      IX_VEND_H: glob_val = VENDOR_ID[15:8];
      IX_VEND_L: glob_val = VENDOR_ID[7:0];
      IX_PCHK:   glob_val = PORT_CHECK;
      default:   glob_val = '0;
    endcase
  end

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NDEV; i++)
      if (devsel_q == DW'(i)) sel_val = bank_rd[i];
    if (!sel_ok) sel_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= '1;
    else if (val_rd)
      rd_q <= !cfg_open ? '1 : (ptr_q < IX_BANKED) ? glob_val : sel_val;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/sio_cfg_chk.sv
module sio_cfg_chk #(
  parameter int         NDEV      = 2,
  parameter logic [7:0] ENTRY_KEY = 8'h87,
  parameter logic [7:0] EXIT_KEY  = 8'hAA
) (
  input logic               clk,
  input logic               rst,
  input logic               ptr_wr,
  input logic               val_wr,
  input logic               val_rd,
  input logic [7:0]         wr_data,
  input logic [7:0]         rd_data,
  input logic [NDEV-1:0]    fn_enable,
  input logic [16*NDEV-1:0] fn_base,
  input logic [8*NDEV-1:0]  fn_irq,
  input logic               cfg_open,
  input logic               key_half
);
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $countones({ptr_wr, val_wr, val_rd}) <= 1);

  assert_open_needs_two_keys_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_open) |-> $past(key_half) && $past(ptr_wr) && $past(wr_data) == ENTRY_KEY);

  assert_exit_closes_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && ptr_wr && wr_data == EXIT_KEY) |=> !cfg_open);

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !val_rd |=> $stable(rd_data));

  assert_shut_read_ff_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_open && val_rd) |=> rd_data == 8'hFF);

  assert_shut_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> $stable(fn_enable) && $stable(fn_base) && $stable(fn_irq));

  assert_no_val_wr_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !val_wr |=> $stable(fn_enable) && $stable(fn_base) && $stable(fn_irq));
endmodule

bind sio_cfg_port sio_cfg_chk #(.NDEV(NDEV), .ENTRY_KEY(ENTRY_KEY), .EXIT_KEY(EXIT_KEY)) u_chk (.*);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  localparam int NDEV = 2;
  localparam logic [7:0] KEY_IN = 8'h87, KEY_OUT = 8'hAA;
  localparam logic [15:0] CHIP = 16'h0C21, VEND = 16'h5A3C;
  localparam logic [7:0] PCHK = 8'h4E;

  logic clk = 0, rst = 1, ptr_wr = 0, val_wr = 0, val_rd = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [NDEV-1:0] fn_enable;
  logic [16*NDEV-1:0] fn_base;
  logic [8*NDEV-1:0] fn_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  bit m_open, m_half;
  logic [7:0] m_ptr, m_sel;
  logic [7:0] m_en [NDEV], m_bh [NDEV], m_bl [NDEV], m_irq [NDEV];

  sio_cfg_port #(.NDEV(NDEV)) u_dut (
    .clk(clk), .rst(rst), .ptr_wr(ptr_wr), .val_wr(val_wr), .val_rd(val_rd),
    .wr_data(wr_data), .rd_data(rd_data), .fn_enable(fn_enable),
    .fn_base(fn_base), .fn_irq(fn_irq)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] exp_read();
    if (!m_open) return 8'hFF;
    case (m_ptr)
      8'h07: return m_sel;
      8'h20: return CHIP[15:8];
      8'h21: return CHIP[7:0];
      8'h23: return VEND[15:8];
      8'h24: return VEND[7:0];
      8'h26: return PCHK;
      default: ;
    endcase
    if (m_ptr < 8'h30 || m_sel >= NDEV) return 8'h00;
    case (m_ptr)
      8'h30: return m_en[m_sel];
      8'h60: return m_bh[m_sel];
      8'h61: return m_bl[m_sel];
      8'h70: return m_irq[m_sel];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    for (int i = 0; i < NDEV; i++) begin
      check(req, {31'd0, fn_enable[i]}, {31'd0, m_en[i][0]});
      check(req, {16'd0, fn_base[i*16 +: 16]}, {16'd0, m_bh[i], m_bl[i]});
      check(req, {24'd0, fn_irq[i*8 +: 8]}, {24'd0, m_irq[i]});
    end
  endtask

  task automatic ptr_write(logic [7:0] b);
    @(negedge clk); ptr_wr = 1; wr_data = b;
    @(negedge clk); ptr_wr = 0;
    if (m_open) begin
      if (b == KEY_OUT) m_open = 0; else m_ptr = b;
    end else if (m_half) begin
      m_half = 0; m_open = (b == KEY_IN);
    end else m_half = (b == KEY_IN);
  endtask

  task automatic val_write(logic [7:0] b);
    @(negedge clk); val_wr = 1; wr_data = b;
    @(negedge clk); val_wr = 0;
    if (m_open) begin
      if (m_ptr == 8'h07) m_sel = b;
      else if (m_ptr >= 8'h30 && m_sel < NDEV) begin
        case (m_ptr)
          8'h30: m_en[m_sel] = b;
          8'h60: m_bh[m_sel] = b;
          8'h61: m_bl[m_sel] = b;
          8'h70: m_irq[m_sel] = b;
          default: ;
        endcase
      end
    end
  endtask

  task automatic val_read(string req, output logic [7:0] got);
    @(negedge clk); val_rd = 1;
    @(negedge clk); val_rd = 0;
    got = rd_data;
    check(req, {24'd0, got}, {24'd0, exp_read()});
  endtask

  task automatic unlock();
    ptr_write(KEY_IN); ptr_write(KEY_IN);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] pool [14] = '{8'h87, 8'hAA, 8'h07, 8'h20, 8'h21, 8'h23, 8'h24,
                              8'h26, 8'h30, 8'h60, 8'h61, 8'h70, 8'h05, 8'h45};
    void'($urandom(1234));
    m_open = 0; m_half = 0; m_ptr = 0; m_sel = 0;
    for (int i = 0; i < NDEV; i++) begin m_en[i] = 0; m_bh[i] = 0; m_bl[i] = 0; m_irq[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R3 reset rd", {24'd0, rd_data}, 32'hFF);
    check_outs("R5 reset outputs");

    // R8: locked access
    val_read("R8 locked read", r);
    ptr_write(8'h30); val_write(8'hFF);
    check_outs("R8 locked write ignored");

    // R1: interrupted sequence stays locked
    ptr_write(KEY_IN); ptr_write(8'h30); ptr_write(KEY_IN);
    val_read("R1 broken key sequence", r);
    ptr_write(KEY_IN);
    ptr_write(8'h26); val_read("R7 port check", r);
    check("R7 not FF", {31'd0, r == 8'hFF}, 32'd0);

    // R6 identity, writes ignored
    ptr_write(8'h20); val_write(8'h00); val_read("R6 chip hi", r);
    ptr_write(8'h21); val_read("R6 chip lo", r);
    ptr_write(8'h23); val_read("R6 vendor hi", r);
    ptr_write(8'h24); val_write(8'h11); val_read("R6 vendor lo", r);

    // R4/R5 banked access
    ptr_write(8'h07); val_write(8'h01); val_read("R4 devsel", r);
    ptr_write(8'h60); val_write(8'hC3);
    ptr_write(8'h61); val_write(8'h5E);
    ptr_write(8'h70); val_write(8'h0B);
    ptr_write(8'h30); val_write(8'h01);
    check_outs("R5 bank 1 outputs");
    ptr_write(8'h07); val_write(8'h00);
    ptr_write(8'h60); val_read("R4 bank 0 distinct", r);
    ptr_write(8'h21); val_read("R4 global same in bank 0", r);

    // R10 read-modify-write
    ptr_write(8'h07); val_write(8'h01);
    ptr_write(8'h70); val_read("R10 rmw read", r);
    val_write(r | 8'h40); val_read("R10 rmw set bit", r);
    val_write(r & ~8'h02); val_read("R10 rmw clear bit", r);
    check_outs("R10 outputs");

    // R9 out-of-range device and unmapped
    ptr_write(8'h07); val_write(8'h05);
    ptr_write(8'h61); val_write(8'h99); val_read("R9 bank out of range", r);
    check_outs("R9 write ignored");
    ptr_write(8'h45); val_write(8'h77); val_read("R9 unmapped", r);

    // R2 exit
    ptr_write(KEY_OUT); val_read("R2 locked after exit", r);

    // R3 hold without read strobe
    repeat (3) @(negedge clk);
    check("R3 hold", {24'd0, rd_data}, 32'hFF);

    // random mix
    unlock();
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) ptr_write(pool[$urandom_range(0, 13)]);
      else if (op < 6) begin
        if (m_ptr == 8'h07) val_write(8'($urandom_range(0, 2)));
        else val_write(8'($urandom));
        check_outs("R5 random outputs");
      end else val_read("R4 random read", r);
      if (!m_open && $urandom_range(0, 3) == 0) unlock();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule